// File: doc/BRIEF.md
# Bus Access Abort and Timeout Monitor

This block sits between the initiators of an external memory interface and the devices behind it. It takes one access at a time and checks two fault conditions. The first is a rights violation: one chip select is reserved for a single owning initiator, and any other initiator that targets it is refused. The second is a response timeout: the device did not answer within a programmable number of reference-clock ticks. Reads and writes are handled the same way, and a refused or timed-out access is never forwarded or left hanging. The initiator gets a completion with read data zero, and a refused write never reaches the device.

Each fault raises a level interrupt and fills a sticky record: a flag, one error-kind bit, the initiator ID and the faulting address. The first fault is kept until software reads the abort-type register. That read clears the flag and the interrupt. A configuration register holds the 8-bit tick limit, a timeout-enable bit and a full-handshake mode bit. The timeout is armed only when both bits are set.

Top module: `bus_abort_monitor`

## Requirements
- R1: An access to chip select PROT_CS (default 0) is forwarded (`dev_go_o` high in the request cycle) only when `req_id_i` equals OWNER_ID (default 0). Accesses to any other chip select are forwarded for every initiator.
- R2: A violating access is not forwarded. One cycle after it is accepted, `rsp_valid_o` pulses with `rsp_rdata_o` equal to 0.
- R3: A violation sets the abort flag and the restricted-access bit (type register bit 8). It stores the initiator ID in type register bits [ID_W-1:0] and the request address in the address register. The flag reads at type register bit 15.
- R4: A read of the type register (register address 1) clears the flag, and the interrupt falls on the next cycle. The ID and error bits remain readable.
- R5: The timeout is armed only if configuration register (address 0) bit 8 (enable) and bit 9 (full-handshake mode) are both set when the access is accepted. Otherwise the block waits for the device without limit.
- R6: An armed access loads the limit from configuration bits [7:0] and counts down one per `ref_tick_i` while waiting. The tick that takes it to zero aborts the access. This sets the flag, the timeout bit (type bit 9), the ID and the address. A limit of 0 expires on the first tick.
- R7: A device acknowledge in the same cycle as the expiring tick wins. The device data is returned and no abort is recorded.
- R8: A timed-out access completes toward the initiator one cycle after expiry, with `rsp_rdata_o` equal to 0.
- R9: While the flag is set, later faults still complete with 0. They do not change the recorded ID, address or error bits.
- R10: `irq_o` is high exactly while the abort flag is set.
- R11: At most one access is outstanding. While the block waits, `dev_go_o` stays low and new requests are not accepted. A device acknowledge returns `dev_rdata_i` on `rsp_rdata_o` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request strobe |
| req_id_i | input | ID_W | Initiator ID |
| req_cs_i | input | CS_W | Target chip select |
| req_addr_i | input | ADDR_W | Requested address |
| dev_go_o | output | 1 | Access forwarded to the device |
| dev_ack_i | input | 1 | Device response |
| dev_rdata_i | input | DATA_W | Device read data |
| rsp_valid_o | output | 1 | Completion toward the initiator |
| rsp_rdata_o | output | DATA_W | Completion read data |
| ref_tick_i | input | 1 | Reference-clock tick |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address: 0 config, 1 abort type, 2 abort address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| irq_o | output | 1 | Abort interrupt, level |

## Verification
A stuck wait state shows up straight away. `dev_go_o` stays low for later requests, and the scoreboard's next expected completion never arrives. A timeout counter that is off by one tick moves the zero-data completion one cycle earlier or later than the bench's tick count. An overwritten record appears on the next register read, as a second initiator ID or address. A flag that is not cleared keeps `irq_o` high on the cycle after the type register is read.

// File: rtl/bam_pkg.sv
package bam_pkg;
  localparam int REG_W         = 32;
  localparam int CFG_EN_BIT    = 8;
  localparam int CFG_HS_BIT    = 9;
  localparam int CFG_USED      = 10;
  localparam int TYPE_RES_BIT  = 8;
  localparam int TYPE_TO_BIT   = 9;
  localparam int TYPE_FLAG_BIT = 15;

  localparam logic [1:0] REG_CFG  = 2'd0;
  localparam logic [1:0] REG_TYPE = 2'd1;
  localparam logic [1:0] REG_ADDR = 2'd2;

  typedef enum logic {ST_IDLE, ST_WAIT} acc_state_e;
  typedef enum logic [1:0] {AB_NONE, AB_RESTRICT, AB_TIMEOUT} abort_kind_e;
endpackage

// File: rtl/bam_access_guard.sv
module bam_access_guard #(
  parameter int          ID_W     = 2,
  parameter int          CS_W     = 3,
  parameter int unsigned PROT_CS  = 0,
  parameter int unsigned OWNER_ID = 0
) (
  input  logic [ID_W-1:0] req_id_i,
  input  logic [CS_W-1:0] req_cs_i,
  output logic            violation_o
);
  localparam logic [CS_W-1:0] PROT_CS_V  = CS_W'(PROT_CS);
  localparam logic [ID_W-1:0] OWNER_ID_V = ID_W'(OWNER_ID);

  assign violation_o = (req_cs_i == PROT_CS_V) && (req_id_i != OWNER_ID_V);
endmodule

// File: rtl/bam_timeout_ctr.sv
module bam_timeout_ctr #(
  parameter int TO_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            arm_i,
  input  logic [TO_W-1:0] limit_i,
  input  logic            active_i,
  input  logic            tick_i,
  input  logic            ack_i,
  output logic            expire_o
);
  logic [TO_W-1:0] cnt_q;
  logic            armed_q;
  logic            step;

  assign step     = active_i && armed_q && tick_i && !ack_i;
  assign expire_o = step && (cnt_q <= TO_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= limit_i;
      armed_q <= arm_i;
    end else if (expire_o) begin
      armed_q <= 1'b0;
    end else if (step) begin
      cnt_q <= cnt_q - TO_W'(1);
    end
  end

  AST_CNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && !start_i && (cnt_q > TO_W'(1)) |=> cnt_q == $past(cnt_q) - TO_W'(1)); // R6
endmodule

// File: rtl/bam_abort_record.sv
module bam_abort_record
  import bam_pkg::*;
#(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  abort_kind_e       kind_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              clr_i,
  output logic              flag_o,
  output logic              res_o,
  output logic              to_o,
  output logic [ID_W-1:0]   id_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic capture;

  // a read in the same cycle frees the record for the new fault
  assign capture = evt_i && (!flag_o || clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      res_o  <= 1'b0;
      to_o   <= 1'b0;
      id_o   <= '0;
      addr_o <= '0;
    end else begin
      if (capture) begin
        res_o  <= (kind_i == AB_RESTRICT);
        to_o   <= (kind_i == AB_TIMEOUT);
        id_o   <= id_i;
        addr_o <= addr_i;
      end
      if (evt_i)      flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end

  AST_SET_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> flag_o); // R3
  AST_CLR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !evt_i |=> !flag_o); // R4
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !clr_i |=> $stable(addr_o) && $stable(id_o) && $stable(res_o) && $stable(to_o)); // R9
endmodule

// File: rtl/bus_abort_monitor.sv
module bus_abort_monitor
  import bam_pkg::*;
#(
  parameter int          ID_W     = 2,
  parameter int          CS_W     = 3,
  parameter int          ADDR_W   = 24,
  parameter int          DATA_W   = 16,
  parameter int          TO_W     = 8,
  parameter int unsigned PROT_CS  = 0,
  parameter int unsigned OWNER_ID = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ID_W-1:0]   req_id_i,
  input  logic [CS_W-1:0]   req_cs_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              dev_go_o,
  input  logic              dev_ack_i,
  input  logic [DATA_W-1:0] dev_rdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              ref_tick_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  acc_state_e        state_q;
  logic [TO_W-1:0]   limit_q;
  logic              to_en_q, hs_mode_q;
  logic [ID_W-1:0]   cur_id_q;
  logic [ADDR_W-1:0] cur_addr_q;

  logic accept, violation, viol, expire, waiting, done_ack;
  logic rec_flag, rec_res, rec_to, rec_clr, abort_evt;
  logic [ID_W-1:0]   rec_id;
  logic [ADDR_W-1:0] rec_addr;
  abort_kind_e       abort_kind;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata_i[REG_W-1:CFG_USED];

  bam_access_guard #(
    .ID_W(ID_W), .CS_W(CS_W), .PROT_CS(PROT_CS), .OWNER_ID(OWNER_ID)
  ) u_guard (
    .req_id_i   (req_id_i),
    .req_cs_i   (req_cs_i),
    .violation_o(violation)
  );

  assign waiting  = (state_q == ST_WAIT);
  assign accept   = req_valid_i && !waiting;
  assign viol     = accept && violation;
  assign dev_go_o = accept && !violation;
  assign done_ack = waiting && dev_ack_i;

  bam_timeout_ctr #(.TO_W(TO_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (dev_go_o),
    .arm_i   (to_en_q && hs_mode_q),
    .limit_i (limit_q),
    .active_i(waiting),
    .tick_i  (ref_tick_i),
    .ack_i   (dev_ack_i),
    .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cur_id_q    <= '0;
      cur_addr_q  <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (dev_go_o) begin
        state_q    <= ST_WAIT;
        cur_id_q   <= req_id_i;
        cur_addr_q <= req_addr_i;
      end else if (viol) begin
        rsp_valid_o <= 1'b1;
        rsp_rdata_o <= '0;
      end else if (done_ack) begin
        state_q     <= ST_IDLE;
        rsp_valid_o <= 1'b1;
        rsp_rdata_o <= dev_rdata_i;
      end else if (expire) begin
        state_q     <= ST_IDLE;
        rsp_valid_o <= 1'b1;
        rsp_rdata_o <= '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      limit_q   <= '0;
      to_en_q   <= 1'b0;
      hs_mode_q <= 1'b0;
    end else if (reg_wr_i && reg_addr_i == REG_CFG) begin
      limit_q   <= reg_wdata_i[TO_W-1:0];
      to_en_q   <= reg_wdata_i[CFG_EN_BIT];
      hs_mode_q <= reg_wdata_i[CFG_HS_BIT];
    end
  end

  assign abort_evt  = viol || expire;
  assign abort_kind = viol ? AB_RESTRICT : (expire ? AB_TIMEOUT : AB_NONE);
  assign rec_clr    = reg_rd_i && (reg_addr_i == REG_TYPE);

  bam_abort_record #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_record (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (abort_evt),
    .kind_i(abort_kind),
    .id_i  (viol ? req_id_i : cur_id_q),
    .addr_i(viol ? req_addr_i : cur_addr_q),
    .clr_i (rec_clr),
    .flag_o(rec_flag),
    .res_o (rec_res),
    .to_o  (rec_to),
    .id_o  (rec_id),
    .addr_o(rec_addr)
  );

  assign irq_o = rec_flag;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_CFG: begin
        reg_rdata_o[TO_W-1:0]   = limit_q;
        reg_rdata_o[CFG_EN_BIT] = to_en_q;
        reg_rdata_o[CFG_HS_BIT] = hs_mode_q;
      end
      REG_TYPE: begin
        reg_rdata_o[ID_W-1:0]      = rec_id;
        reg_rdata_o[TYPE_RES_BIT]  = rec_res;
        reg_rdata_o[TYPE_TO_BIT]   = rec_to;
        reg_rdata_o[TYPE_FLAG_BIT] = rec_flag;
      end
      REG_ADDR: reg_rdata_o = REG_W'(rec_addr);
      default:  reg_rdata_o = '0;
    endcase
  end

  AST_VIOL_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol |=> rsp_valid_o && rsp_rdata_o == '0); // R2
  AST_TO_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> rsp_valid_o && rsp_rdata_o == '0 && state_q == ST_IDLE); // R8
  AST_ACK_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_ack |=> rsp_valid_o && rsp_rdata_o == $past(dev_rdata_i) && !$rose(irq_o)); // R7
  AST_BUSY_NO_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waiting |-> !dev_go_o); // R11
endmodule

// File: tb/bus_abort_monitor_bench.sv
module bus_abort_monitor_bench;
  localparam int ID_W = 2, CS_W = 3, ADDR_W = 24, DATA_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [ID_W-1:0] req_id = '0;
  logic [CS_W-1:0] req_cs = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic dev_go, dev_ack = 1'b0;
  logic [DATA_W-1:0] dev_rdata = '0;
  logic rsp_valid;
  logic [DATA_W-1:0] rsp_rdata;
  logic ref_tick = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;

  int errors = 0, checks = 0, cyc = 0;
  logic [DATA_W-1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  bus_abort_monitor u_bus_abort_monitor (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_id_i(req_id),
    .req_cs_i(req_cs), .req_addr_i(req_addr), .dev_go_o(dev_go),
    .dev_ack_i(dev_ack), .dev_rdata_i(dev_rdata), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata), .ref_tick_i(ref_tick), .reg_wr_i(reg_wr),
    .reg_rd_i(reg_rd), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  // driver side of the scoreboard
  task automatic expect_rsp(input logic [DATA_W-1:0] d, input string req);
    exp_q.push_back(d);
    tag_q.push_back(req);
  endtask

  // monitor side
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected completion", 32'(rsp_rdata), 32'hx);
      end else begin
        automatic logic [DATA_W-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rsp_rdata == e, t, 32'(rsp_rdata), 32'(e));
      end
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cycle();
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, input logic [31:0] exp, input string req);
    reg_rd = 1'b1; reg_addr = a;
    #1 check(reg_rdata == exp, req, reg_rdata, exp);
    cycle();
    reg_rd = 1'b0;
  endtask

  task automatic request(input logic [ID_W-1:0] id, input logic [CS_W-1:0] cs,
                         input logic [ADDR_W-1:0] a, input bit go_exp, input string req);
    req_valid = 1'b1; req_id = id; req_cs = cs; req_addr = a;
    #1 check(dev_go == go_exp, req, 32'(dev_go), 32'(go_exp));
    cycle();
    req_valid = 1'b0;
  endtask

  task automatic ack(input logic [DATA_W-1:0] d);
    dev_ack = 1'b1; dev_rdata = d;
    cycle();
    dev_ack = 1'b0;
  endtask

  task automatic ticks(input int n);
    ref_tick = 1'b1;
    repeat (n) cycle();
    ref_tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      check(1'b0, "watchdog", 32'(cyc), 32'd20000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(irq == 1'b0, "reset irq R10", 32'(irq), 0);
    check(rsp_valid == 1'b0, "reset rsp", 32'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    reg_read(2'd0, 32'h0, "reset cfg R5");
    reg_read(2'd1, 32'h0, "reset type R3");

    reg_write(2'd0, 32'h305);

    // owner access to the protected select, busy blocking
    request(2'd0, 3'd0, 24'h000100, 1'b1, "R1 owner forwarded");
    req_valid = 1'b1; req_id = 2'd1; req_cs = 3'd1;
    #1 check(dev_go == 1'b0, "R11 no go while busy", 32'(dev_go), 0);
    req_valid = 1'b0;
    expect_rsp(16'hABCD, "R11 ack data");
    ack(16'hABCD);
    check(irq == 1'b0, "R10 no irq", 32'(irq), 0);

    request(2'd1, 3'd1, 24'h000010, 1'b1, "R1 other cs forwarded");
    expect_rsp(16'h1234, "R11 ack data 2");
    ack(16'h1234);

    // violation
    expect_rsp(16'h0, "R2 violation read zero");
    request(2'd1, 3'd0, 24'h00ABC0, 1'b0, "R2 violation not forwarded");
    check(irq == 1'b1, "R10 irq on violation", 32'(irq), 1);
    reg_read(2'd2, 32'h0000ABC0, "R3 abort address");

    expect_rsp(16'h0, "R9 second violation zero");
    request(2'd2, 3'd0, 24'h000777, 1'b0, "R1 dsp refused");
    reg_read(2'd2, 32'h0000ABC0, "R9 address kept");
    reg_read(2'd1, 32'h00008101, "R3 type record");
    check(irq == 1'b0, "R4 irq cleared", 32'(irq), 0);
    reg_read(2'd1, 32'h00000101, "R4 flag clear, fields kept");

    // timeout after 5 ticks
    request(2'd0, 3'd2, 24'h002000, 1'b1, "R6 timed access go");
    ticks(4);
    check(rsp_valid == 1'b0, "R6 no expiry before limit", 32'(rsp_valid), 0);
    expect_rsp(16'h0, "R8 timeout read zero");
    ticks(1);
    check(irq == 1'b1, "R6 irq on timeout", 32'(irq), 1);
    reg_read(2'd2, 32'h00002000, "R6 timeout address");
    reg_read(2'd1, 32'h00008200, "R6 timeout type");

    // ack on the expiring tick wins
    reg_write(2'd0, 32'h303);
    request(2'd0, 3'd3, 24'h000030, 1'b1, "R7 go");
    ticks(2);
    ref_tick = 1'b1;
    expect_rsp(16'h5A5A, "R7 ack wins data");
    ack(16'h5A5A);
    ref_tick = 1'b0;
    check(irq == 1'b0, "R7 no abort", 32'(irq), 0);

    // handshake mode only: unarmed
    reg_write(2'd0, 32'h201);
    request(2'd0, 3'd1, 24'h000040, 1'b1, "R5 go");
    ticks(10);
    check(rsp_valid == 1'b0 && irq == 1'b0, "R5 no timeout without enable",
          {30'h0, rsp_valid, irq}, 0);
    expect_rsp(16'h0F0F, "R5 late ack data");
    ack(16'h0F0F);

    // enable only: unarmed
    reg_write(2'd0, 32'h101);
    request(2'd0, 3'd1, 24'h000050, 1'b1, "R5 go 2");
    ticks(10);
    check(irq == 1'b0, "R5 no timeout without handshake mode", 32'(irq), 0);
    expect_rsp(16'h00F0, "R5 late ack data 2");
    ack(16'h00F0);

    // limit 0 expires on first tick
    reg_write(2'd0, 32'h300);
    request(2'd3, 3'd5, 24'h000055, 1'b1, "R6 go limit0");
    expect_rsp(16'h0, "R8 limit0 zero");
    ticks(1);
    reg_read(2'd1, 32'h00008203, "R6 limit0 record");
    check(irq == 1'b0, "R4 cleared again", 32'(irq), 0);

    cycle();
    check(exp_q.size() == 0, "R11 all completions seen", exp_q.size(), 0);
    finish_run();
  end
endmodule